// File: doc/BRIEF.md
# USB OUT Endpoint Double-Buffer Controller

This block controls the receive side of a USB OUT endpoint that buffers up to two packets. It sits between the serial engine and the CPU. The serial engine writes packet bytes at a write pointer, then reports the end of each packet together with its data PID. The CPU reads bytes at a read pointer and then releases each packet, either explicitly or automatically. The block counts the packets held and tracks the expected data toggle. It picks the handshake reply for each OUT transaction and rewinds the write pointer when a packet must be thrown away.

A six-bit control word sets the transfer type, the stall state and the release policy. Three bits in that word are one-shot requests: toggle reset, flush of the oldest packet, and release of the packet just read. Each request acts on the clock edge after the write and then clears itself. The byte storage, the bit-level line coding and the CRC are outside this block.

Top module: `usb_out_dbuf_ctrl`

## Requirements
- R1: After reset, buf_sts_o is 2'b00, both pointers are 0, ctl_rdata_o is 0 and hs_valid_o is 0.
- R2: buf_sts_o encodes the packets held as 2'b00 (none), 2'b01 (one) or 2'b11 (two). Storing a packet steps it up one level and releasing a packet steps it down one level.
- R3: In bulk/interrupt mode (ctl bit 2 = 0), a packet whose PID bit (0 = DATA0, 1 = DATA1) equals the expected toggle is stored when a buffer is free. It gets ACK (hs_o = 2'b01) and flips the expected toggle. A packet with the other PID also gets ACK, but it is discarded and wr_ptr_o returns to its value before the packet.
- R4: In bulk/interrupt mode with two packets held, a packet gets NAK (hs_o = 2'b10). It is discarded and the expected toggle is left unchanged.
- R5: While the stall bit (ctl bit 3) is 1 in bulk/interrupt mode, every packet gets STALL (hs_o = 2'b11) and is discarded. Normal replies resume once the bit is written back to 0.
- R6: In isochronous mode (ctl bit 2 = 1), the reply is none (hs_o = 2'b00) and the PID is not checked. A packet that arrives with two packets held is dropped and wr_ptr_o is rewound.
- R7: Writing 1 to the flush bit (ctl bit 1) releases only the oldest packet and moves rd_ptr_o to that packet's end. The bit reads back 1 for one cycle and then 0.
- R8: A flush or clear-ready request made with no packet held changes neither the status nor the pointers, and the request bit still clears itself on the next cycle.
- R9: With the auto bit (ctl bit 4) set to 1, a CPU read that reaches the end of the oldest packet releases that packet on the same clock edge.
- R10: With the auto bit at 0, reading a whole packet leaves the status unchanged. Writing 1 to the clear-ready bit (ctl bit 5) then releases the packet on the following edge.
- R11: Writing 1 to the toggle-reset bit (ctl bit 0) sets the expected PID to DATA0, zeroes both pointers and empties the buffers on the next edge, and the bit then reads back 0.
- R12: hs_valid_o pulses for exactly one cycle, in the cycle after the edge that samples pkt_end_i, with the reply on hs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 6 | Control word: [0] toggle reset, [1] flush, [2] iso, [3] stall, [4] auto, [5] clear-ready |
| ctl_rdata_o | output | 6 | Control word readback |
| wr_byte_i | input | 1 | Serial engine wrote one byte at wr_ptr_o |
| pkt_end_i | input | 1 | End of a good data packet |
| pkt_pid_i | input | 1 | Data PID of that packet (0 = DATA0, 1 = DATA1) |
| rd_byte_i | input | 1 | CPU read one byte at rd_ptr_o |
| hs_valid_o | output | 1 | Handshake reply valid |
| hs_o | output | 2 | Reply: 00 none, 01 ACK, 10 NAK, 11 STALL |
| buf_sts_o | output | 2 | Buffer occupancy flags |
| wr_ptr_o | output | PTR_W | FIFO write pointer |
| rd_ptr_o | output | PTR_W | FIFO read pointer |

## Verification
The bench drives the toggle through a stored packet, a mismatched packet, a NAK while full and a STALL. It then checks that the next stored PID follows the toggle. A design that flipped the toggle on a discard would NAK or discard the wrong packet. The flush test holds two packets and checks that the read pointer jumps to the end of the older one only. A design that emptied the buffer or dropped the newer packet would show a wrong status or pointer. Empty-buffer requests, the auto-release edge, rewinding after a toggle reset, and isochronous drops with a PID that bulk mode would reject are each checked at the pointers and the status flags.

// File: rtl/usb_out_pkg.sv
package usb_out_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int CTL_W      = 6;
  localparam int B_TOG_RST  = 0;
  localparam int B_FLUSH    = 1;
  localparam int B_ISO      = 2;
  localparam int B_STALL    = 3;
  localparam int B_AUTO     = 4;
  localparam int B_CLR_RDY  = 5;

  function automatic logic [1:0] occ_to_sts(input logic [1:0] occ);
    return {occ == 2'd2, occ != 2'd0};
  endfunction
endpackage

// File: rtl/usb_out_ctl_regs.sv
module usb_out_ctl_regs
  import usb_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             iso_o,
  output logic             stall_o,
  output logic             auto_o,
  output logic             tog_rst_o,
  output logic             flush_o,
  output logic             clr_rdy_o,
  output logic [CTL_W-1:0] rdata_o
);
  logic iso_q, stall_q, auto_q, tog_q, flush_q, clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iso_q   <= 1'b0;
      stall_q <= 1'b0;
      auto_q  <= 1'b0;
      tog_q   <= 1'b0;
      flush_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      // one-shot bits: live for one cycle after the write
      tog_q   <= we_i & wdata_i[B_TOG_RST];
      flush_q <= we_i & wdata_i[B_FLUSH];
      clr_q   <= we_i & wdata_i[B_CLR_RDY];
      if (we_i) begin
        iso_q   <= wdata_i[B_ISO];
        stall_q <= wdata_i[B_STALL];
        auto_q  <= wdata_i[B_AUTO];
      end
    end
  end

  assign iso_o     = iso_q;
  assign stall_o   = stall_q;
  assign auto_o    = auto_q;
  assign tog_rst_o = tog_q;
  assign flush_o   = flush_q;
  assign clr_rdy_o = clr_q;

  always_comb begin
    rdata_o            = '0;
    rdata_o[B_TOG_RST] = tog_q;
    rdata_o[B_FLUSH]   = flush_q;
    rdata_o[B_ISO]     = iso_q;
    rdata_o[B_STALL]   = stall_q;
    rdata_o[B_AUTO]    = auto_q;
    rdata_o[B_CLR_RDY] = clr_q;
  end

  AST_FLUSH_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_q && !we_i) |=> !flush_q); // R7
  AST_TOG_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tog_q && !we_i) |=> !tog_q); // R11
endmodule

// File: rtl/usb_out_hs_decide.sv
module usb_out_hs_decide
  import usb_out_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pkt_end_i,
  input  logic       pkt_pid_i,
  input  logic       iso_i,
  input  logic       stall_i,
  input  logic       full_i,
  input  logic       tog_rst_i,
  output logic       store_o,
  output logic       discard_o,
  output logic       hs_valid_o,
  output logic [1:0] hs_o
);
  logic exp_q;
  hs_e  hs_d, hs_q;
  logic vld_q;

  always_comb begin
    store_o   = 1'b0;
    discard_o = 1'b0;
    hs_d      = HS_NONE;
    if (pkt_end_i && !tog_rst_i) begin
      if (iso_i) begin
        if (full_i) discard_o = 1'b1;
        else        store_o   = 1'b1;
      end else if (stall_i) begin
        hs_d      = HS_STALL;
        discard_o = 1'b1;
      end else if (full_i) begin
        hs_d      = HS_NAK;
        discard_o = 1'b1;
      end else if (pkt_pid_i != exp_q) begin
        hs_d      = HS_ACK;
        discard_o = 1'b1;
      end else begin
        hs_d    = HS_ACK;
        store_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= 1'b0;
      hs_q  <= HS_NONE;
      vld_q <= 1'b0;
    end else begin
      vld_q <= pkt_end_i;
      hs_q  <= hs_d;
      if (tog_rst_i)            exp_q <= 1'b0;
      else if (store_o && !iso_i) exp_q <= ~exp_q;
    end
  end

  assign hs_valid_o = vld_q;
  assign hs_o       = hs_q;

  AST_STALL_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && stall_i && !iso_i && !tog_rst_i) |=> (hs_valid_o && hs_o == HS_STALL)); // R5
  AST_ISO_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && iso_i) |=> (hs_o == HS_NONE)); // R6
  AST_NAK_KEEPS_TOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_end_i && full_i && !iso_i && !tog_rst_i) |=> $stable(exp_q)); // R4
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_valid_o && !$past(pkt_end_i)) |-> 1'b0); // R12
endmodule

// File: rtl/usb_out_buf_track.sv
module usb_out_buf_track #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_byte_i,
  input  logic             rd_byte_i,
  input  logic             store_i,
  input  logic             discard_i,
  input  logic             flush_i,
  input  logic             clr_rdy_i,
  input  logic             auto_i,
  input  logic             tog_rst_i,
  output logic [1:0]       occ_o,
  output logic             full_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  localparam int NSLOT = 2;

  logic [PTR_W-1:0] wr_q, cmt_q, rd_q;
  logic [PTR_W-1:0] end_q [NSLOT];
  logic             hd_q;
  logic [1:0]       occ_q;
  logic             tail;
  logic [PTR_W-1:0] head_end;
  logic             auto_rel, rel;

  assign tail     = hd_q ^ occ_q[0];
  assign head_end = end_q[hd_q];
  assign auto_rel = auto_i && rd_byte_i && (occ_q != 2'd0) &&
                    ((rd_q + PTR_W'(1)) == head_end);
  assign rel      = (occ_q != 2'd0) && (flush_i || clr_rdy_i || auto_rel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
      hd_q  <= 1'b0;
      occ_q <= 2'd0;
      for (int i = 0; i < NSLOT; i++) end_q[i] <= '0;
    end else if (tog_rst_i) begin
      wr_q  <= '0;
      cmt_q <= '0;
      rd_q  <= '0;
      hd_q  <= 1'b0;
      occ_q <= 2'd0;
      for (int i = 0; i < NSLOT; i++) end_q[i] <= '0;
    end else begin
      if (discard_i)      wr_q <= cmt_q;
      else if (wr_byte_i) wr_q <= wr_q + PTR_W'(1);
      if (store_i) begin
        cmt_q       <= wr_q;
        end_q[tail] <= wr_q;
      end
      if (rel)            rd_q <= head_end;
      else if (rd_byte_i) rd_q <= rd_q + PTR_W'(1);
      if (rel) hd_q <= ~hd_q;
      case ({store_i, rel})
        2'b10:   occ_q <= occ_q + 2'd1;
        2'b01:   occ_q <= occ_q - 2'd1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign occ_o    = occ_q;
  assign full_o   = occ_q == 2'd2;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !store_i); // R4
  AST_OCC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q != 2'd3); // R2
  AST_FLUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && occ_q != 2'd0 && !store_i && !tog_rst_i) |=> (occ_q == $past(occ_q) - 2'd1)); // R7
  AST_EMPTY_REQ_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == 2'd0 && (flush_i || clr_rdy_i) && !store_i && !rd_byte_i && !tog_rst_i)
      |=> (occ_q == 2'd0 && $stable(rd_q))); // R8
endmodule

// File: rtl/usb_out_dbuf_ctrl.sv
module usb_out_dbuf_ctrl
  import usb_out_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [5:0]       ctl_wdata_i,
  output logic [5:0]       ctl_rdata_o,
  input  logic             wr_byte_i,
  input  logic             pkt_end_i,
  input  logic             pkt_pid_i,
  input  logic             rd_byte_i,
  output logic             hs_valid_o,
  output logic [1:0]       hs_o,
  output logic [1:0]       buf_sts_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  logic iso, stall, auto_en, tog_rst, flush, clr_rdy;
  logic store, discard, full;
  logic [1:0] occ;

  usb_out_ctl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .iso_o     (iso),
    .stall_o   (stall),
    .auto_o    (auto_en),
    .tog_rst_o (tog_rst),
    .flush_o   (flush),
    .clr_rdy_o (clr_rdy),
    .rdata_o   (ctl_rdata_o)
  );

  usb_out_hs_decide u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_end_i  (pkt_end_i),
    .pkt_pid_i  (pkt_pid_i),
    .iso_i      (iso),
    .stall_i    (stall),
    .full_i     (full),
    .tog_rst_i  (tog_rst),
    .store_o    (store),
    .discard_o  (discard),
    .hs_valid_o (hs_valid_o),
    .hs_o       (hs_o)
  );

  usb_out_buf_track #(.DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_byte_i (wr_byte_i),
    .rd_byte_i (rd_byte_i),
    .store_i   (store),
    .discard_i (discard),
    .flush_i   (flush),
    .clr_rdy_i (clr_rdy),
    .auto_i    (auto_en),
    .tog_rst_i (tog_rst),
    .occ_o     (occ),
    .full_o    (full),
    .wr_ptr_o  (wr_ptr_o),
    .rd_ptr_o  (rd_ptr_o)
  );

  assign buf_sts_o = occ_to_sts(occ);

  AST_STS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_sts_o != 2'b10); // R2
  AST_TOG_RST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[B_TOG_RST]) |=> (buf_sts_o == 2'b00 && wr_ptr_o == '0 && rd_ptr_o == '0)); // R11
endmodule

// File: tb/usb_out_dbuf_ctrl_tb.sv
module usb_out_dbuf_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [5:0] ctl_rdata;
  logic wr_byte = 1'b0, pkt_end = 1'b0, pkt_pid = 1'b0, rd_byte = 1'b0;
  logic hs_valid;
  logic [1:0] hs, sts;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_out_dbuf_ctrl #(.DEPTH(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .wr_byte_i(wr_byte), .pkt_end_i(pkt_end),
    .pkt_pid_i(pkt_pid), .rd_byte_i(rd_byte), .hs_valid_o(hs_valid), .hs_o(hs),
    .buf_sts_o(sts), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick();
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic send_pkt(input int n, input logic pid);
    for (int i = 0; i < n; i++) begin
      wr_byte = 1'b1; tick();
    end
    wr_byte = 1'b0;
    pkt_end = 1'b1; pkt_pid = pid;
    tick();
    pkt_end = 1'b0; pkt_pid = 1'b0;
  endtask

  task automatic read_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      rd_byte = 1'b1; tick();
    end
    rd_byte = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sts", sts, 0);
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 rd_ptr", rd_ptr, 0);
    chk("R1 rdata", ctl_rdata, 0);
    chk("R1 hs_valid", hs_valid, 0);
  endtask

  task automatic t_bulk_toggle();
    send_pkt(3, 1'b0);
    chk("R12 hs_valid", hs_valid, 1);
    chk("R3 ACK store", hs, 1);
    chk("R2 sts one", sts, 1);
    chk("R3 wr_ptr", wr_ptr, 3);
    tick();
    chk("R12 pulse one cycle", hs_valid, 0);
    send_pkt(2, 1'b0);
    chk("R3 mismatch ACK", hs, 1);
    chk("R3 mismatch sts", sts, 1);
    chk("R3 mismatch rewind", wr_ptr, 3);
    send_pkt(4, 1'b1);
    chk("R3 second ACK", hs, 1);
    chk("R2 sts two", sts, 3);
    chk("R3 wr_ptr 7", wr_ptr, 7);
  endtask

  task automatic t_full_nak();
    send_pkt(2, 1'b0);
    chk("R4 NAK", hs, 2);
    chk("R4 sts", sts, 3);
    chk("R4 rewind", wr_ptr, 7);
  endtask

  task automatic t_manual_release();
    read_bytes(3);
    chk("R10 held after read", sts, 3);
    chk("R10 rd_ptr", rd_ptr, 3);
    wr_ctl(6'b100000);
    chk("R10 clr bit set", ctl_rdata, 6'b100000);
    tick();
    chk("R10 released", sts, 1);
    chk("R10 clr bit cleared", ctl_rdata, 0);
    // toggle unchanged by NAK: DATA0 expected now
    send_pkt(1, 1'b0);
    chk("R4 toggle kept ACK", hs, 1);
    chk("R4 toggle kept sts", sts, 3);
    chk("R4 wr_ptr 8", wr_ptr, 8);
  endtask

  task automatic t_flush();
    wr_ctl(6'b000010);
    chk("R7 flush bit set", ctl_rdata[1], 1);
    tick();
    chk("R7 sts one left", sts, 1);
    chk("R7 rd_ptr oldest end", rd_ptr, 7);
    chk("R7 flush bit cleared", ctl_rdata[1], 0);
  endtask

  task automatic t_auto();
    wr_ctl(6'b010000);
    read_bytes(1);
    chk("R9 auto rd_ptr", rd_ptr, 8);
    chk("R9 auto released", sts, 0);
  endtask

  task automatic t_empty_req();
    wr_ctl(6'b010010);
    tick();
    chk("R8 flush empty sts", sts, 0);
    chk("R8 flush empty rd", rd_ptr, 8);
    chk("R8 flush bit cleared", ctl_rdata, 6'b010000);
    wr_ctl(6'b110000);
    tick();
    chk("R8 clr empty sts", sts, 0);
    chk("R8 clr empty rd", rd_ptr, 8);
    chk("R8 clr bit cleared", ctl_rdata, 6'b010000);
  endtask

  task automatic t_stall();
    wr_ctl(6'b011000);
    send_pkt(2, 1'b1);
    chk("R5 STALL", hs, 3);
    chk("R5 sts", sts, 0);
    chk("R5 rewind", wr_ptr, 8);
    wr_ctl(6'b010000);
    send_pkt(2, 1'b1);
    chk("R5 resume ACK", hs, 1);
    chk("R5 resume sts", sts, 1);
    chk("R5 resume wr", wr_ptr, 10);
  endtask

  task automatic t_tog_reset();
    send_pkt(1, 1'b0);
    chk("R11 pre sts", sts, 3);
    wr_ctl(6'b010001);
    chk("R11 bit set", ctl_rdata[0], 1);
    tick();
    chk("R11 bit cleared", ctl_rdata[0], 0);
    chk("R11 sts empty", sts, 0);
    chk("R11 wr zero", wr_ptr, 0);
    chk("R11 rd zero", rd_ptr, 0);
    send_pkt(1, 1'b0);
    chk("R11 DATA0 accepted", sts, 1);
    chk("R11 wr 1", wr_ptr, 1);
    read_bytes(1);
    chk("R9 auto second", sts, 0);
  endtask

  task automatic t_iso();
    wr_ctl(6'b010100);
    send_pkt(2, 1'b0);
    chk("R6 no handshake", hs, 0);
    chk("R6 valid", hs_valid, 1);
    chk("R6 no pid check", sts, 1);
    chk("R6 wr 3", wr_ptr, 3);
    send_pkt(1, 1'b0);
    chk("R6 sts two", sts, 3);
    send_pkt(2, 1'b1);
    chk("R6 drop hs", hs, 0);
    chk("R6 drop sts", sts, 3);
    chk("R6 drop rewind", wr_ptr, 4);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_bulk_toggle();
    t_full_nak();
    t_manual_release();
    t_flush();
    t_auto();
    t_empty_req();
    t_stall();
    t_tog_reset();
    t_iso();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule